// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block steps a processor clock domain among four operating modes: normal-high, doze, deep-sleep and power-down. Software asks for a low-power mode with a one-cycle request. The controller then watches the wake-up sources and brings the domain back to normal-high. Those sources are a pending-interrupt flag, four timer-type wake sources (real-time clock, periodic timer, time base and decrementer, each with its own enable) and a hard-reset input. The PLL is switched off in deep-sleep and power-down. Leaving either of those modes therefore passes through a counted relock interval, and the domain is declared ready only when that interval ends. The interval is shorter when the PLL runs in one-to-one mode.

The block also holds a sticky timer-expired status bit and drives an external pin that mirrors it. An enabled timer wake source sets the bit in any mode. Power-down has only one exit, a hard reset. External logic is expected to raise that reset when it sees the expiry pin. Software clears the bit with a write-one-to-clear pulse. The whole block runs on the PLL-input reference clock, so the relock count is kept in reference-clock cycles.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After the synchronous reset `rst_n` is released, the outputs show `cur_mode`=0 (normal-high), `ready`=1, `pll_en`=1, `texp_stat`=0 and `texp_pin`=0.
- R2: Mode codes are 0 normal-high, 1 doze, 2 deep-sleep and 3 power-down. When `ready` is 1 and `req_valid` is 1, `cur_mode` takes the value of `req_mode` on the next cycle. A request with code 0 has no effect. `pll_en` is 0 in codes 2 and 3 and is 1 otherwise. `ready` is 1 only in settled normal-high.
- R3: In doze, `irq_pending` returns the block to normal-high with `ready`=1 on the next cycle. Timer wake sources do not end doze.
- R4: In deep-sleep, `irq_pending` or any timer source whose enable bit is set starts the exit. Wake source bit order is 0 real-time clock, 1 periodic timer, 2 time base and 3 decrementer. A source whose enable bit is clear does not wake the block.
- R5: On a deep-sleep wake, `cur_mode` becomes 0 and `pll_en` becomes 1 on the next cycle. `ready` then stays 0 for exactly 500 cycles counted from the wake edge. The count is 100 cycles if `pll_one_to_one` is 1 at that edge.
- R6: In power-down, neither `irq_pending` nor any timer source changes `cur_mode`. Only `hard_reset` leaves power-down.
- R7: A timer source whose enable bit is set makes `texp_stat` 1 on the next cycle, in any mode. A source whose enable bit is clear does not. `texp_pin` always equals `texp_stat`.
- R8: A one-cycle pulse on `texp_clr` clears `texp_stat` and `texp_pin`. If a setting event arrives in the same cycle, the set wins.
- R9: `hard_reset` sets `texp_stat` and makes `cur_mode` 0 on the next cycle. From deep-sleep, power-down or an ongoing relock, it starts a fresh relock count as in R5. From normal-high or doze, `ready` is 1 at once.
- R10: A request made while `ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL-input reference clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| req_valid | input | 1 | One-cycle low-power mode request |
| req_mode | input | 2 | Requested mode code |
| irq_pending | input | 1 | Interrupt pending from the interrupt controller |
| wake_src | input | NSRC | Timer wake requests (RTC, periodic, time base, decrementer) |
| wake_en | input | NSRC | Per-source enable bits |
| pll_one_to_one | input | 1 | PLL one-to-one mode select |
| hard_reset | input | 1 | Functional hard-reset request |
| texp_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| pll_en | output | 1 | PLL enable |
| cur_mode | output | 2 | Current mode code |
| ready | output | 1 | Settled in normal-high, ready for requests |
| texp_stat | output | 1 | Sticky timer-expired status |
| texp_pin | output | 1 | External expiry pin, mirrors the status |

## Verification
The assertions check several properties on every cycle. Power-down holds unless hard reset is seen. Doze always exits on an interrupt, and hard reset always forces mode code 0. The status bit sets on an enabled source and stays set until cleared. The relock counter stays within range, and `ready` never appears while the PLL is off. The bench scenarios are needed for the rest: the exact 500- and 100-cycle relock lengths, the restart of the count by a hard reset in mid-relock, and the ignoring of requests and of disabled sources. These are measured against a behavioural model compared on every clock.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power wake-up controller.
// Assumes the two-bit mode code is visible to software, so its values are fixed.
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_DOZE   = 2'd1,
        MODE_DEEP   = 2'd2,
        MODE_PDOWN  = 2'd3
    } lpm_mode_e;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_DOZE,
        ST_DEEP,
        ST_PDOWN,
        ST_RELOCK
    } lpm_state_e;

endpackage

// File: rtl/lpm_relock_timer.sv
// Counts the PLL relock interval in reference-clock cycles.
// A start pulse loads the long or short length and restarts any count already
// running. expired is high during the last cycle of the interval.
module lpm_relock_timer #(
    parameter int unsigned LONG_CYC  = 500,
    parameter int unsigned SHORT_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sel_short,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(LONG_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    // Load on start, otherwise count down while busy and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= sel_short ? CNT_W'(SHORT_CYC - 1) : CNT_W'(LONG_CYC - 1);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expired = busy_q && (cnt_q == '0);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < CNT_W'(LONG_CYC))); // R5
    AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !start) |=> !busy_q); // R5

endmodule

// File: rtl/lpm_expiry_status.sv
// Sticky timer-expired status bit with its mirror pin.
// An enabled timer source or a hard reset sets the bit, and a clear pulse
// resets it. When both arrive together the set wins. Also reports whether any
// enabled source is active, for use by the mode sequencer.
module lpm_expiry_status #(
    parameter int unsigned NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] wake_src,
    input  logic [NSRC-1:0] wake_en,
    input  logic            hard_reset,
    input  logic            clr,
    output logic            src_hit,
    output logic            stat
);
    logic stat_q;

    assign src_hit = |(wake_src & wake_en);

    // Set has priority over the write-one-to-clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (src_hit || hard_reset) begin
            stat_q <= 1'b1;
        end else if (clr) begin
            stat_q <= 1'b0;
        end
    end

    assign stat = stat_q;

    AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wake_src & wake_en) || hard_reset) |=> stat_q); // R7
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !clr) |=> stat_q); // R8
    AST_STAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_q && !(|(wake_src & wake_en)) && !hard_reset) |=> !stat_q); // R7

endmodule

// File: rtl/lpm_mode_fsm.sv
// Mode sequencer: normal-high, doze, deep-sleep, power-down and relock.
// The relock state reports mode code 0 with the PLL on, but ready stays low
// until the timer expires. Hard reset has priority over every other event.
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic       irq_pending,
    input  logic       src_hit,
    input  logic       hard_reset,
    input  logic       relock_done,
    output logic       relock_start,
    output logic [1:0] cur_mode,
    output logic       ready,
    output logic       pll_en
);
    lpm_state_e st_q, st_d;

    // Next-state selection and relock start request.
    always_comb begin
        st_d         = st_q;
        relock_start = 1'b0;
        if (hard_reset) begin
            if (st_q == ST_DEEP || st_q == ST_PDOWN || st_q == ST_RELOCK) begin
                st_d         = ST_RELOCK;
                relock_start = 1'b1;
            end else begin
                st_d = ST_NORMAL;
            end
        end else begin
            unique case (st_q)
                ST_NORMAL: begin
                    if (req_valid) begin
                        case (lpm_mode_e'(req_mode))
                            MODE_DOZE:  st_d = ST_DOZE;
                            MODE_DEEP:  st_d = ST_DEEP;
                            MODE_PDOWN: st_d = ST_PDOWN;
                            default:    st_d = ST_NORMAL;
                        endcase
                    end
                end
                ST_DOZE: begin
                    if (irq_pending) st_d = ST_NORMAL;
                end
                ST_DEEP: begin
                    if (irq_pending || src_hit) begin
                        st_d         = ST_RELOCK;
                        relock_start = 1'b1;
                    end
                end
                ST_PDOWN:  st_d = ST_PDOWN;
                ST_RELOCK: begin
                    if (relock_done) st_d = ST_NORMAL;
                end
                default:   st_d = ST_NORMAL;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_NORMAL;
        end else begin
            st_q <= st_d;
        end
    end

    // Output decode from the registered state.
    always_comb begin
        unique case (st_q)
            ST_DOZE:  cur_mode = MODE_DOZE;
            ST_DEEP:  cur_mode = MODE_DEEP;
            ST_PDOWN: cur_mode = MODE_PDOWN;
            default:  cur_mode = MODE_NORMAL;
        endcase
    end

    assign ready  = (st_q == ST_NORMAL);
    assign pll_en = !(st_q == ST_DEEP || st_q == ST_PDOWN);

    AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PDOWN && !hard_reset) |=> (cur_mode == MODE_PDOWN)); // R6
    AST_DOZE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DOZE && irq_pending && !hard_reset) |=> ready); // R3
    AST_DEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DEEP && (irq_pending || src_hit) && !hard_reset)
        |=> (pll_en && !ready)); // R4
    AST_HRST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        hard_reset |=> (cur_mode == MODE_NORMAL)); // R9
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RELOCK && !relock_done && !hard_reset) |=> !ready); // R10
    AST_READY_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> pll_en); // R2

endmodule

// File: rtl/lpm_wake_ctrl.sv
// Top of the low-power wake-up controller.
// Assumes that clk is the PLL-input reference clock, that rst_n is synchronous
// and that all inputs are already synchronous to clk.
module lpm_wake_ctrl #(
    parameter int unsigned NSRC      = 4,
    parameter int unsigned LONG_CYC  = 500,
    parameter int unsigned SHORT_CYC = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_mode,
    input  logic            irq_pending,
    input  logic [NSRC-1:0] wake_src,
    input  logic [NSRC-1:0] wake_en,
    input  logic            pll_one_to_one,
    input  logic            hard_reset,
    input  logic            texp_clr,
    output logic            pll_en,
    output logic [1:0]      cur_mode,
    output logic            ready,
    output logic            texp_stat,
    output logic            texp_pin
);
    logic src_hit;
    logic relock_start;
    logic relock_done;
    logic stat;

    // Sticky expiry status and combined source hit.
    lpm_expiry_status #(.NSRC(NSRC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_src   (wake_src),
        .wake_en    (wake_en),
        .hard_reset (hard_reset),
        .clr        (texp_clr),
        .src_hit    (src_hit),
        .stat       (stat)
    );

    // Relock interval counter.
    lpm_relock_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (relock_start),
        .sel_short (pll_one_to_one),
        .expired   (relock_done)
    );

    // Mode sequencer.
    lpm_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_mode     (req_mode),
        .irq_pending  (irq_pending),
        .src_hit      (src_hit),
        .hard_reset   (hard_reset),
        .relock_done  (relock_done),
        .relock_start (relock_start),
        .cur_mode     (cur_mode),
        .ready        (ready),
        .pll_en       (pll_en)
    );

    assign texp_stat = stat;
    assign texp_pin  = stat;

endmodule

// File: tb/lpm_wake_ctrl_tb.sv
module lpm_wake_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_mode = 2'd0;
    logic            irq_pending = 1'b0;
    logic [NSRC-1:0] wake_src = '0;
    logic [NSRC-1:0] wake_en = '0;
    logic            pll_one_to_one = 1'b0;
    logic            hard_reset = 1'b0;
    logic            texp_clr = 1'b0;
    logic            pll_en;
    logic [1:0]      cur_mode;
    logic            ready;
    logic            texp_stat;
    logic            texp_pin;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string phase = "R1 reset";

    lpm_wake_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .irq_pending(irq_pending), .wake_src(wake_src), .wake_en(wake_en),
        .pll_one_to_one(pll_one_to_one), .hard_reset(hard_reset),
        .texp_clr(texp_clr), .pll_en(pll_en), .cur_mode(cur_mode),
        .ready(ready), .texp_stat(texp_stat), .texp_pin(texp_pin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model: 0 normal,1 doze,2 deep,3 pdown,4 relock.
    int m_state = 0;
    int m_left  = 0;
    bit m_stat  = 1'b0;

    always @(posedge clk) begin
        bit tw;
        bit nst;
        if (!rst_n) begin
            m_state = 0; m_left = 0; m_stat = 1'b0;
        end else begin
            tw  = |(wake_src & wake_en);
            nst = m_stat;
            if (texp_clr) nst = 1'b0;
            if (tw || hard_reset) nst = 1'b1;
            if (hard_reset) begin
                if (m_state >= 2) begin
                    m_state = 4; m_left = pll_one_to_one ? 100 : 500;
                end else begin
                    m_state = 0;
                end
            end else begin
                case (m_state)
                    0: if (req_valid && req_mode != 2'd0) m_state = int'(req_mode);
                    1: if (irq_pending) m_state = 0;
                    2: if (irq_pending || tw) begin
                           m_state = 4; m_left = pll_one_to_one ? 100 : 500;
                       end
                    4: begin
                           m_left = m_left - 1;
                           if (m_left == 0) m_state = 0;
                       end
                    default: ;
                endcase
            end
            m_stat = nst;
        end
    end

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
        end
    endtask

    // Compare every output against the model a quarter period after each edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!finished) begin
            cmp("cur_mode", int'(cur_mode), (m_state == 4) ? 0 : m_state);
            cmp("ready", int'(ready), int'(m_state == 0));
            cmp("pll_en", int'(pll_en), int'(!(m_state == 2 || m_state == 3)));
            cmp("texp_stat", int'(texp_stat), int'(m_stat));
            cmp("texp_pin", int'(texp_pin), int'(m_stat));
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(logic [1:0] m);
        req_valid = 1'b1; req_mode = m;
        step(1);
        req_valid = 1'b0;
    endtask

    // Called just after the wake edge: counts cycles until ready returns.
    task automatic measure(output int n);
        n = 0;
        while (!ready && n < 2000) begin
            n++;
            step(1);
        end
    endtask

    initial begin
        int n;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 mode", int'(cur_mode), 0);
        chk("R1 ready", int'(ready), 1);
        chk("R1 pll", int'(pll_en), 1);
        chk("R1 stat", int'(texp_stat), 0);

        phase = "R2 doze entry";
        request(2'd1);
        chk("R2 doze mode", int'(cur_mode), 1);
        phase = "R3 doze timers";
        wake_en = 4'hF; wake_src = 4'b0001;
        step(1);
        wake_src = '0;
        chk("R3 doze held", int'(cur_mode), 1);
        chk("R7 stat set", int'(texp_stat), 1);
        chk("R7 pin", int'(texp_pin), 1);
        irq_pending = 1'b1;
        step(1);
        irq_pending = 1'b0;
        chk("R3 doze exit ready", int'(ready), 1);

        phase = "R8 clear";
        texp_clr = 1'b1;
        step(1);
        texp_clr = 1'b0;
        chk("R8 cleared", int'(texp_stat), 0);
        chk("R8 pin cleared", int'(texp_pin), 0);

        phase = "R2 code zero";
        request(2'd0);
        chk("R2 code zero ignored", int'(ready), 1);

        phase = "R4 deep disabled source";
        wake_en = 4'b0111;
        request(2'd2);
        chk("R2 deep pll off", int'(pll_en), 0);
        wake_src = 4'b1000;
        step(2);
        wake_src = '0;
        chk("R4 disabled held", int'(cur_mode), 2);
        chk("R7 disabled no set", int'(texp_stat), 0);

        phase = "R5 long relock";
        wake_src = 4'b0100;
        step(1);
        wake_src = '0;
        chk("R5 pll on", int'(pll_en), 1);
        n = 0;
        while (!ready && n < 2000) begin
            n++;
            req_valid = (n == 3); req_mode = 2'd3;
            step(1);
        end
        req_valid = 1'b0;
        chk("R5 long count", n, 500);
        chk("R10 request ignored", int'(cur_mode), 0);
        texp_clr = 1'b1; step(1); texp_clr = 1'b0;

        phase = "R5 short relock";
        pll_one_to_one = 1'b1;
        request(2'd2);
        irq_pending = 1'b1;
        step(1);
        irq_pending = 1'b0;
        pll_one_to_one = 1'b0;
        measure(n);
        chk("R5 short count", n, 100);

        phase = "R6 power-down";
        request(2'd3);
        irq_pending = 1'b1; wake_src = 4'hF;
        step(3);
        irq_pending = 1'b0; wake_src = '0;
        chk("R6 held", int'(cur_mode), 3);
        chk("R7 stat in pdown", int'(texp_stat), 1);
        texp_clr = 1'b1; step(1); texp_clr = 1'b0;
        phase = "R9 hard reset pdown";
        hard_reset = 1'b1;
        step(1);
        hard_reset = 1'b0;
        chk("R9 stat set", int'(texp_stat), 1);
        chk("R9 mode", int'(cur_mode), 0);
        measure(n);
        chk("R9 relock count", n, 500);

        phase = "R9 restart";
        request(2'd2);
        irq_pending = 1'b1; step(1); irq_pending = 1'b0;
        step(50);
        hard_reset = 1'b1; step(1); hard_reset = 1'b0;
        measure(n);
        chk("R9 restarted count", n, 500);

        phase = "R9 doze";
        request(2'd1);
        hard_reset = 1'b1; step(1); hard_reset = 1'b0;
        chk("R9 doze ready", int'(ready), 1);

        phase = "R8 set wins";
        texp_clr = 1'b1; wake_src = 4'b0001;
        step(1);
        texp_clr = 1'b0; wake_src = '0;
        chk("R8 set wins", int'(texp_stat), 1);
        step(2);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule